// File: doc/BRIEF.md
# Latched Serial Control Register

This block takes an eleven-bit control frame from a host microcontroller over three slow wires: a serial clock, a data line and a latch line, plus an active-low asynchronous reset. While the latch line is low, each rising edge of the serial clock appends the data bit to a shift register. While the latch line is high (from its rising edge onward), the holding register copies the shift register and drives the control outputs. While the latch line is low again, the outputs keep the last frame.

The host lines are brought into the block's system clock domain through synchronizers, and the edges are detected there. The holding register drives ten open-drain style enables (1 = released, 0 = pulled low) and two internal flags: an AGC enable and a deck-select flag. The flags and two mode inputs feed a decoder that picks the playback equalizer time constant and the record equalizer tape type.

Top module: `serctl_latch_reg`

## Requirements
- R1: While `rst_n` is low, asynchronously and without waiting for a clock edge, `ctl_rel` is all ones and `agc_en` and `deck_b` are 1.
- R2: A bit is taken into the shift register only on a rising edge of `host_clk` seen while `host_latch` is low. The frame is sent first bit D1 through last bit D11.
- R3: While `host_latch` is low, `ctl_rel`, `agc_en` and `deck_b` do not change, even while new bits are shifted in.
- R4: While `host_latch` is high, the holding register takes the shift register contents. Rising `host_clk` edges in that time are ignored, so a second latch pulse with no bits in between gives the same outputs.
- R5: Output map, with index 0 the least significant bit: `ctl_rel[0..6]` = D1..D7, `ctl_rel[7]` = D9, `ctl_rel[8]` = D11 and `ctl_rel[9]` = D11.
- R6: `agc_en` = D8 (1 enables the AGC) and `deck_b` = D10 (0 selects deck A, 1 selects deck B). Neither bit reaches `ctl_rel`.
- R7: `pb_eq_fast` (1 = 70 µs, 0 = 120 µs). With `deck_b` = 0 it equals `a_sel`. With `deck_b` = 1 it is 0 when `tape_lvl` is low and 1 when `tape_lvl` is medium or high.
- R8: `tape_lvl` encoding: 2'b00 is low, 2'b01 is medium, 2'b10 and 2'b11 are high. `rec_eq` is 0 (normal) for low, 1 (chrome) for medium and 2 (metal) for high.
- R9: A change on `host_latch` reaches the outputs on the third rising `clk` edge after the pin changes, and not before.
- R10: Reset fills the shift register with ones. A latch pulse after reset, with no clocks in between, keeps all outputs and flags at 1.
- R11: If more than eleven bits are shifted before a latch, only the last eleven form the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_clk | input | 1 | Serial clock from the host |
| host_data | input | 1 | Serial data from the host |
| host_latch | input | 1 | Latch line from the host |
| a_sel | input | 1 | Deck A playback time-constant select |
| tape_lvl | input | 2 | Three-level tape-type input |
| ctl_rel | output | 10 | Open-drain enables, 1 = released |
| agc_en | output | 1 | AGC enable (D8) |
| deck_b | output | 1 | Deck select flag (D10) |
| pb_eq_fast | output | 1 | Playback time constant, 1 = 70 µs |
| rec_eq | output | 2 | Record equalizer type 0/1/2 |

## Verification
Each host pin passes through two synchronizer flops, and one more register stage acts on it. So a change on the latch or clock line reaches the outputs on the third system clock edge. The decoder outputs follow the holding register and the mode inputs in the same cycle. The bench drives every pin at a falling system edge and holds each host level for several cycles. For the latency requirement, it samples at the falling edges after the second and the third rising edge. Reset is checked a fraction of a cycle after it is applied, before any clock edge.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int FRAME_W = 11;
  localparam int CTL_W   = 10;
  localparam int BIT_AGC  = 7;   // D8
  localparam int BIT_DECK = 9;   // D10

  typedef enum logic [1:0] {
    REQ_NORMAL = 2'd0,
    REQ_CHROME = 2'd1,
    REQ_METAL  = 2'd2
  } rec_eq_e;

  typedef logic [FRAME_W-1:0] frame_t;   // index k-1 holds Dk

  // Shift register holds the first bit at its top: reorder to D1 at index 0.
  function automatic frame_t order_frame(input logic [FRAME_W-1:0] sr);
    frame_t d;
    for (int k = 0; k < FRAME_W; k++) d[k] = sr[FRAME_W-1-k];
    return d;
  endfunction

  function automatic logic [CTL_W-1:0] map_ctl(input frame_t d);
    logic [CTL_W-1:0] c;
    for (int k = 0; k < 7; k++) c[k] = d[k];
    c[7] = d[8];
    c[8] = d[10];
    c[9] = d[10];
    return c;
  endfunction

  function automatic logic lvl_is_low(input logic [1:0] lvl);
    return (lvl == 2'b00);
  endfunction

  function automatic logic pick_pb_fast(input logic deck, input logic a_sel,
                                        input logic [1:0] lvl);
    return deck ? !lvl_is_low(lvl) : a_sel;
  endfunction

  function automatic rec_eq_e pick_rec(input logic [1:0] lvl);
    rec_eq_e r;
    unique case (lvl)
      2'b00:   r = REQ_NORMAL;
      2'b01:   r = REQ_CHROME;
      default: r = REQ_METAL;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/scr_sync.sv
module scr_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/scr_frame_core.sv
module scr_frame_core
  import scr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clk_rise,
  input  logic   latch_lvl,
  input  logic   data_bit,
  output frame_t frame_o
);
  logic [FRAME_W-1:0] sr_q;
  logic [FRAME_W-1:0] hold_q;
  logic               shift_ev;
  logic               load_ev;

  assign shift_ev = clk_rise && !latch_lvl;
  assign load_ev  = latch_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr_q <= '1;
    else if (shift_ev) sr_q <= {sr_q[FRAME_W-2:0], data_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '1;
    else if (load_ev) hold_q <= sr_q;
  end

  assign frame_o = order_frame(hold_q);

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_RELEASED: assert (hold_q == '1 && sr_q == '1); // R1
    end
  end

  AST_HOLD_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_lvl |=> $stable(hold_q)); // R3
  AST_SHIFT_ONLY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !(clk_rise && !latch_lvl) |=> $stable(sr_q)); // R4
  AST_SHIFT_APPEND: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_rise && !latch_lvl) |=> (sr_q[0] == $past(data_bit))); // R2
  AST_COPY_ON_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    latch_lvl |=> (hold_q == $past(sr_q))); // R4
endmodule

// File: rtl/scr_eq_select.sv
module scr_eq_select
  import scr_pkg::*;
(
  input  logic       deck,
  input  logic       a_sel,
  input  logic [1:0] lvl,
  output logic       pb_fast,
  output rec_eq_e    rec_eq
);
  always_comb begin
    pb_fast = pick_pb_fast(deck, a_sel, lvl);
    rec_eq  = pick_rec(lvl);
  end
endmodule

// File: rtl/serctl_latch_reg.sv
module serctl_latch_reg
  import scr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_clk,
  input  logic             host_data,
  input  logic             host_latch,
  input  logic             a_sel,
  input  logic [1:0]       tape_lvl,
  output logic [CTL_W-1:0] ctl_rel,
  output logic             agc_en,
  output logic             deck_b,
  output logic             pb_eq_fast,
  output logic [1:0]       rec_eq
);
  localparam int  N_LINES = 3;
  localparam logic [N_LINES-1:0] LINE_RST = 3'b001; // host_clk idles high after reset

  logic [N_LINES-1:0] line_raw;
  logic [N_LINES-1:0] line_s;
  logic               hclk_prev_q;
  logic               hclk_rise;
  frame_t             frame;
  rec_eq_e            rec_sel;

  assign line_raw = {host_latch, host_data, host_clk};

  for (genvar i = 0; i < N_LINES; i++) begin : g_sync
    scr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(LINE_RST[i])) u_sync (
      .clk(clk), .rst_n(rst_n), .d(line_raw[i]), .q(line_s[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hclk_prev_q <= 1'b1;
    else        hclk_prev_q <= line_s[0];
  end

  assign hclk_rise = line_s[0] && !hclk_prev_q;

  scr_frame_core u_core (
    .clk(clk), .rst_n(rst_n), .clk_rise(hclk_rise),
    .latch_lvl(line_s[2]), .data_bit(line_s[1]), .frame_o(frame)
  );

  assign ctl_rel = map_ctl(frame);
  assign agc_en  = frame[BIT_AGC];
  assign deck_b  = frame[BIT_DECK];

  scr_eq_select u_eq (
    .deck(deck_b), .a_sel(a_sel), .lvl(tape_lvl),
    .pb_fast(pb_eq_fast), .rec_eq(rec_sel)
  );
  assign rec_eq = rec_sel;

  AST_DECK_A_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !deck_b |-> (pb_eq_fast == a_sel)); // R7
  AST_REC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rec_eq != 2'd3); // R8
  AST_MUTE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rel[8] == ctl_rel[9]); // R5
endmodule

// File: tb/serctl_latch_reg_tb_top.sv
module serctl_latch_reg_tb_top;
  localparam int HP = 6;       // host half period in system cycles
  localparam int MIN_W = 4;    // bench-side host timing minimum
  localparam int WDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic host_clk = 1'b0, host_data = 1'b0, host_latch = 1'b0;
  logic a_sel = 1'b0;
  logic [1:0] tape_lvl = 2'b00;
  logic [9:0] ctl_rel;
  logic agc_en, deck_b, pb_eq_fast;
  logic [1:0] rec_eq;

  int checks = 0;
  int errors = 0;
  int tviol = 0;

  always #10 clk = ~clk;

  serctl_latch_reg dut_i (
    .clk(clk), .rst_n(rst_n), .host_clk(host_clk), .host_data(host_data),
    .host_latch(host_latch), .a_sel(a_sel), .tape_lvl(tape_lvl),
    .ctl_rel(ctl_rel), .agc_en(agc_en), .deck_b(deck_b),
    .pb_eq_fast(pb_eq_fast), .rec_eq(rec_eq)
  );

  // host timing monitor: pulse widths and data stability while clock high
  int hi_cnt = 0, lo_cnt = 0;
  logic hclk_d = 1'b0, hdata_d = 1'b0;
  always @(posedge clk) begin
    if (host_clk) hi_cnt <= hi_cnt + 1; else lo_cnt <= lo_cnt + 1;
    if (host_clk && !hclk_d) begin
      if (lo_cnt < MIN_W) tviol <= tviol + 1;
      lo_cnt <= 0;
    end
    if (!host_clk && hclk_d) begin
      if (hi_cnt < MIN_W) tviol <= tviol + 1;
      hi_cnt <= 0;
    end
    if (host_clk && hclk_d && host_data != hdata_d) tviol <= tviol + 1;
    hclk_d <= host_clk;
    hdata_d <= host_data;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_sys(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [9:0] exp_ctl(input logic [10:0] f);
    return {f[10], f[10], f[8], f[6:0]};
  endfunction

  task automatic check_frame(input logic [10:0] f, input string req);
    check(ctl_rel == exp_ctl(f), req, ctl_rel, exp_ctl(f));
    check(agc_en == f[7], req, agc_en, f[7]);
    check(deck_b == f[9], req, deck_b, f[9]);
  endtask

  task automatic host_bit(input logic b);
    host_data = b;
    wait_sys(HP);
    host_clk = 1'b1;
    wait_sys(HP);
    host_clk = 1'b0;
    wait_sys(HP);
  endtask

  // shift n bits, bits[0] first; the last clock falls after latch rises
  task automatic shift_and_latch(input logic [15:0] bits, input int n);
    for (int i = 0; i < n - 1; i++) host_bit(bits[i]);
    host_data = bits[n-1];
    wait_sys(HP);
    host_clk = 1'b1;
    wait_sys(HP);
    host_latch = 1'b1;
    wait_sys(HP);
    host_clk = 1'b0;
    wait_sys(HP);
  endtask

  task automatic latch_low;
    host_latch = 1'b0;
    wait_sys(HP);
  endtask

  task automatic send_frame(input logic [10:0] f);
    shift_and_latch({5'b0, f}, 11);
    latch_low();
  endtask

  task automatic t_reset_state;
    @(negedge clk) rst_n = 1'b0;
    wait_sys(3);
    check(ctl_rel == 10'h3ff, "R1 reset ctl", ctl_rel, 10'h3ff);
    check(agc_en && deck_b, "R1 reset flags", {agc_en, deck_b}, 2'b11);
    @(negedge clk) rst_n = 1'b1;
    wait_sys(HP);
  endtask

  task automatic t_map_patterns;
    logic [10:0] pats [4] = '{11'h000, 11'h555, 11'h2aa, 11'h0f3};
    for (int i = 0; i < 4; i++) begin
      send_frame(pats[i]);
      check_frame(pats[i], "R5 R6 R2 map");
    end
    for (int k = 0; k < 11; k++) begin
      logic [10:0] f = 11'h7ff ^ (11'h1 << k);
      send_frame(f);
      check_frame(f, "R5 R6 single bit");
    end
  endtask

  task automatic t_hold_low;
    logic [10:0] a = 11'h1c5, b = 11'h63a;
    send_frame(a);
    for (int i = 0; i < 11; i++) host_bit(b[i]);
    check_frame(a, "R3 hold while low");
    host_latch = 1'b1;
    wait_sys(HP);
    latch_low();
    check_frame(b, "R3 new frame after latch");
  endtask

  task automatic t_latch_high_ignore;
    logic [10:0] a = 11'h2d1;
    send_frame(a);
    host_latch = 1'b1;
    wait_sys(HP);
    host_bit(1'b0);
    host_bit(1'b1);
    host_bit(1'b0);
    check_frame(a, "R4 clocks ignored while high");
    latch_low();
    host_latch = 1'b1;
    wait_sys(HP);
    latch_low();
    check_frame(a, "R4 repeat latch same frame");
  endtask

  task automatic t_latency;
    logic [10:0] a = 11'h000, b = 11'h7ff;
    send_frame(a);
    for (int i = 0; i < 11; i++) host_bit(b[i]);
    @(negedge clk) host_latch = 1'b1;
    wait_sys(2);
    check(ctl_rel == exp_ctl(a), "R9 not before third edge", ctl_rel, exp_ctl(a));
    wait_sys(1);
    check(ctl_rel == exp_ctl(b), "R9 on third edge", ctl_rel, exp_ctl(b));
    latch_low();
  endtask

  task automatic t_reset_refill;
    send_frame(11'h000);
    host_bit(1'b0);
    host_bit(1'b0);
    @(negedge clk) rst_n = 1'b0;
    #2;
    check(ctl_rel == 10'h3ff, "R1 async reset", ctl_rel, 10'h3ff);
    wait_sys(2);
    @(negedge clk) rst_n = 1'b1;
    wait_sys(HP);
    host_latch = 1'b1;
    wait_sys(HP);
    latch_low();
    check_frame(11'h7ff, "R10 latch after reset");
  endtask

  task automatic t_long_frame;
    logic [12:0] bits = 13'b0_1101_0011_0110;
    logic [10:0] f = bits[12:2];
    shift_and_latch({3'b0, bits}, 13);
    latch_low();
    check_frame(f, "R11 last eleven bits");
  endtask

  task automatic t_eq_modes;
    send_frame(11'h000); // deck A
    for (int s = 0; s < 2; s++) begin
      for (int l = 0; l < 4; l++) begin
        @(negedge clk) a_sel = s[0]; tape_lvl = l[1:0];
        #1 check(pb_eq_fast == s[0], "R7 deck A", pb_eq_fast, s);
      end
    end
    send_frame(11'h200); // deck B
    for (int s = 0; s < 2; s++) begin
      for (int l = 0; l < 4; l++) begin
        @(negedge clk) a_sel = s[0]; tape_lvl = l[1:0];
        #1 check(pb_eq_fast == (l != 0), "R7 deck B", pb_eq_fast, (l != 0));
        check(rec_eq == ((l >= 2) ? 2 : l), "R8 record type", rec_eq, (l >= 2) ? 2 : l);
      end
    end
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1 rst_n = 1'b0;
    wait_sys(3);
    check(ctl_rel == 10'h3ff && agc_en && deck_b, "R1 initial reset", ctl_rel, 10'h3ff);
    @(negedge clk) rst_n = 1'b1;
    wait_sys(HP);
    t_reset_state();
    t_map_patterns();
    t_hold_low();
    t_latch_high_ignore();
    t_latency();
    t_reset_refill();
    t_long_frame();
    t_eq_modes();
    check(tviol == 0, "R2 host timing kept", tviol, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule